// File: doc/BRIEF.md
# USB Controller Interrupt Wrapper

This block gathers the interrupt events of a USB on-the-go core and presents them to a processor through a small bank of 32-bit registers and one level interrupt line. Each hardware event is a one-cycle pulse. The pulse latches a bit in a raw pending register, and that bit stays set until software drops it. Software may also raise or drop any implemented pending bit through dedicated write-one registers. It enables or disables individual sources the same way through a second pair of write-one registers.

The interrupt line is registered and gated by an arm flag. The line rises when the block is armed and at least one enabled source is pending, and the flag is spent at that moment. The line then follows the enabled-pending state. Once it has fallen it stays low, whatever arrives, until software writes the end-of-interrupt register. A typical handler reads the masked view, writes those bits to the clear register, services them, and ends with the end-of-interrupt write.

Top module: `usb_irq_wrap`

## Requirements
- R1: Event pulses latch into the raw register at the next clock edge and stay set until cleared. The mapping is: `txEvt[i]` goes to bit i (bits 0 to 4), `rxEvt[j]` goes to bit 9+j (bits 9 to 12), and `coreEvt[k]` goes to bit 16+k (bits 16 to 24). Bit 24 is the bus-power drive change event.
- R2: Byte offsets: raw pending 0x20 (read), force-set 0x24, force-clear 0x28, enable 0x2C (read), enable-set 0x30, enable-clear 0x34, masked view 0x38 (read), end-of-interrupt 0x3C. Only the bits named in R1 are implemented, so the implemented pattern is 0x01FF1E1F. Other bits read 0 and writes to them have no effect.
- R3: A write to 0x24 sets the raw bits where the data is 1. A write to 0x28 drops the raw bits where the data is 1. Data bits at 0 change nothing. If a hardware event and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: A write to 0x30 sets the enable bits where the data is 1. A write to 0x34 drops the enable bits where the data is 1. No other enable bit changes.
- R5: Offset 0x38 reads the raw register ANDed with the enable register.
- R6: When the block is armed and the masked value is nonzero, `irqOut` is high after the next edge, and the arm flag is spent at that edge.
- R7: After firing, `irqOut` stays high while the masked value is nonzero. Once it has dropped, it stays low until an end-of-interrupt write, even if new enabled sources become pending.
- R8: A write of any value to 0x3C re-arms the block. If the masked value is nonzero in the cycle of that write, `irqOut` is high right after that edge.
- R9: Reset clears the raw and enable registers, drives `irqOut` low and leaves the block armed.
- R10: Unmapped offsets and the write-only offsets (0x24, 0x28, 0x30, 0x34, 0x3C) read 0. Writes to 0x20, 0x2C, 0x38 and unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWe | input | 1 | Write strobe for one cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| txEvt | input | 5 | Transmit endpoint event pulses |
| rxEvt | input | 4 | Receive endpoint event pulses |
| coreEvt | input | 9 | Core USB event pulses, bit 8 is the bus-power drive change |
| irqOut | output | 1 | Level interrupt to the processor |

## Verification
The bench drives a hardware event into a bit in the same cycle as a clear write to that bit. A design that gave the clear priority would lose the event. It lets the line fall and then raises fresh enabled sources before any end-of-interrupt write. A wrapper that simply ORs the masked bits would re-assert there. It writes end-of-interrupt while sources are still pending and checks that the line rises right after that edge; a design that re-arms one cycle late shows up in that case. It also writes to read-only and unmapped offsets and to unimplemented bits, then reads the registers back to confirm that nothing changed.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

  localparam int DATA_W   = 32;
  localparam int TX_LSB   = 0;
  localparam int TX_N     = 5;
  localparam int RX_LSB   = 9;
  localparam int RX_N     = 4;
  localparam int CORE_LSB = 16;
  localparam int CORE_N   = 9;

  localparam logic [7:0] OFF_RAW     = 8'h20;
  localparam logic [7:0] OFF_RAWSET  = 8'h24;
  localparam logic [7:0] OFF_RAWCLR  = 8'h28;
  localparam logic [7:0] OFF_ENA     = 8'h2C;
  localparam logic [7:0] OFF_ENASET  = 8'h30;
  localparam logic [7:0] OFF_ENACLR  = 8'h34;
  localparam logic [7:0] OFF_MASKED  = 8'h38;
  localparam logic [7:0] OFF_EOI     = 8'h3C;

  function automatic logic [DATA_W-1:0] fieldBits(input int lsb, input int n);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int i = 0; i < n; i++) v[lsb+i] = 1'b1;
    return v;
  endfunction

  localparam logic [DATA_W-1:0] IMPL_MASK =
    fieldBits(TX_LSB, TX_N) | fieldBits(RX_LSB, RX_N) | fieldBits(CORE_LSB, CORE_N);

  // Write strobes from the decoder to the register bank
  typedef struct packed {
    logic rawSet;
    logic rawClr;
    logic enaSet;
    logic enaClr;
    logic eoi;
  } strobe_t;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_RAW,
    SEL_ENA,
    SEL_MASKED
  } rdsel_t;

endpackage

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl
  import usb_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobe_t           strb,
  output rdsel_t            rdSel
);

  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFF_RAW);
  localparam logic [ADDR_W-1:0] A_RAWSET = ADDR_W'(OFF_RAWSET);
  localparam logic [ADDR_W-1:0] A_RAWCLR = ADDR_W'(OFF_RAWCLR);
  localparam logic [ADDR_W-1:0] A_ENA    = ADDR_W'(OFF_ENA);
  localparam logic [ADDR_W-1:0] A_ENASET = ADDR_W'(OFF_ENASET);
  localparam logic [ADDR_W-1:0] A_ENACLR = ADDR_W'(OFF_ENACLR);
  localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFF_MASKED);
  localparam logic [ADDR_W-1:0] A_EOI    = ADDR_W'(OFF_EOI);

  // Write decode: only the write-only offsets produce strobes
  always_comb begin
    strb = '0;
    if (busWe) begin
      strb.rawSet = (busAddr == A_RAWSET);
      strb.rawClr = (busAddr == A_RAWCLR);
      strb.enaSet = (busAddr == A_ENASET);
      strb.enaClr = (busAddr == A_ENACLR);
      strb.eoi    = (busAddr == A_EOI);
    end
  end

  // Read decode: everything else reads as zero
  always_comb begin
    rdSel = SEL_NONE;
    if (busAddr == A_RAW)         rdSel = SEL_RAW;
    else if (busAddr == A_ENA)    rdSel = SEL_ENA;
    else if (busAddr == A_MASKED) rdSel = SEL_MASKED;
  end

endmodule

// File: rtl/usb_irq_dpath.sv
module usb_irq_dpath
  import usb_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  rdsel_t            rdSel,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [TX_N-1:0]   txEvt,
  input  logic [RX_N-1:0]   rxEvt,
  input  logic [CORE_N-1:0] coreEvt,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] rawQ,
  output logic [DATA_W-1:0] enaQ,
  output logic              armedQ,
  output logic              irqOut
);

  logic [DATA_W-1:0] hwVec;
  logic              pend;

  always_comb begin
    hwVec = '0;
    hwVec[TX_LSB   +: TX_N]   = txEvt;
    hwVec[RX_LSB   +: RX_N]   = rxEvt;
    hwVec[CORE_LSB +: CORE_N] = coreEvt;
  end

  // One flop pair per implemented bit; the rest tie to zero
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (IMPL_MASK[b]) begin : g_impl
      logic rawBit;
      logic enaBit;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rawBit <= 1'b0;
          enaBit <= 1'b0;
        end else begin
          // set and hardware events take priority over clear
          rawBit <= (rawBit & ~(strb.rawClr & busWdata[b]))
                    | (strb.rawSet & busWdata[b]) | hwVec[b];
          enaBit <= (enaBit & ~(strb.enaClr & busWdata[b]))
                    | (strb.enaSet & busWdata[b]);
        end
      end
      assign rawQ[b] = rawBit;
      assign enaQ[b] = enaBit;
    end else begin : g_tie
      assign rawQ[b] = 1'b0;
      assign enaQ[b] = 1'b0;
    end
  end

  assign pend = |(rawQ & enaQ);

  // Arm flag spent on firing; only an end-of-interrupt write restores it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b1;
      irqOut <= 1'b0;
    end else begin
      irqOut <= pend & (armedQ | strb.eoi | irqOut);
      armedQ <= (armedQ | strb.eoi) & ~pend;
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_RAW:    busRdata = rawQ;
      SEL_ENA:    busRdata = enaQ;
      SEL_MASKED: busRdata = rawQ & enaQ;
      default:    busRdata = '0;
    endcase
  end

endmodule

// File: rtl/usb_irq_wrap.sv
module usb_irq_wrap
  import usb_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [4:0]        txEvt,
  input  logic [3:0]        rxEvt,
  input  logic [8:0]        coreEvt,
  output logic              irqOut
);

  strobe_t           strb;
  rdsel_t            rdSel;
  logic [DATA_W-1:0] rawQ;
  logic [DATA_W-1:0] enaQ;
  logic              armedQ;

  usb_irq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  usb_irq_dpath dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rdSel    (rdSel),
    .busWdata (busWdata),
    .txEvt    (txEvt),
    .rxEvt    (rxEvt),
    .coreEvt  (coreEvt),
    .busRdata (busRdata),
    .rawQ     (rawQ),
    .enaQ     (enaQ),
    .armedQ   (armedQ),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/usb_irq_chk.sv
module usb_irq_chk
  import usb_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic [4:0]        txEvt,
  input logic [3:0]        rxEvt,
  input logic [8:0]        coreEvt,
  input logic [31:0]       rawQ,
  input logic [31:0]       enaQ,
  input logic              armedQ,
  input logic              irqOut
);

  logic [31:0] evVec;
  logic        wrSet, wrClr, wrEnaSet, wrEoi, mapped;

  always_comb begin
    evVec = '0;
    evVec[4:0]   = txEvt;
    evVec[12:9]  = rxEvt;
    evVec[24:16] = coreEvt;
  end

  assign wrSet    = busWe && (busAddr == ADDR_W'(OFF_RAWSET));
  assign wrClr    = busWe && (busAddr == ADDR_W'(OFF_RAWCLR));
  assign wrEnaSet = busWe && (busAddr == ADDR_W'(OFF_ENASET));
  assign wrEoi    = busWe && (busAddr == ADDR_W'(OFF_EOI));
  assign mapped   = (busAddr == ADDR_W'(OFF_RAW)) || (busAddr == ADDR_W'(OFF_ENA))
                 || (busAddr == ADDR_W'(OFF_MASKED));

  AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (evVec != 0) |=> ((rawQ & $past(evVec)) == $past(evVec))); // R1

  AST_SET_FORCES: assert property (@(posedge clk) disable iff (!rstN)
    wrSet |=> ((rawQ & $past(busWdata & IMPL_MASK)) == $past(busWdata & IMPL_MASK))); // R3

  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (wrClr && evVec == 0) |=> ((rawQ & $past(busWdata)) == 0)); // R3

  AST_ENA_SET: assert property (@(posedge clk) disable iff (!rstN)
    wrEnaSet |=> ((enaQ & $past(busWdata & IMPL_MASK)) == $past(busWdata & IMPL_MASK))); // R4

  AST_MASKED_VIEW: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(OFF_MASKED)) |-> (busRdata == (rawQ & enaQ))); // R5

  AST_FIRE_WHEN_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && (rawQ & enaQ) != 0) |=> (irqOut && !armedQ)); // R6

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!irqOut && !armedQ && !wrEoi) |=> !irqOut); // R7

  AST_EOI_REFIRE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEoi && (rawQ & enaQ) != 0) |=> irqOut); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> (busRdata == 0)); // R10

endmodule

bind usb_irq_wrap usb_irq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .txEvt    (txEvt),
  .rxEvt    (rxEvt),
  .coreEvt  (coreEvt),
  .rawQ     (rawQ),
  .enaQ     (enaQ),
  .armedQ   (armedQ),
  .irqOut   (irqOut)
);

// File: tb/usb_irq_wrap_tb_top.sv
module usb_irq_wrap_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VALID_BITS = 32'h01FF1E1F;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [4:0]  txEvt = '0;
  logic [3:0]  rxEvt = '0;
  logic [8:0]  coreEvt = '0;
  logic        irqOut;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  logic [31:0] mRaw = '0;
  logic [31:0] mEna = '0;
  logic        mArm = 1'b1;
  logic        mIrq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_irq_wrap #(.ADDR_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .txEvt(txEvt),
    .rxEvt(rxEvt), .coreEvt(coreEvt), .irqOut(irqOut)
  );

  function automatic logic [31:0] place(input logic [4:0] tx, input logic [3:0] rx,
                                        input logic [8:0] co);
    logic [31:0] v;
    v = '0;
    v[4:0] = tx;
    v[12:9] = rx;
    v[24:16] = co;
    return v;
  endfunction

  function automatic logic [31:0] expRead(input logic [7:0] a);
    case (a)
      8'h20:   return mRaw;
      8'h2C:   return mEna;
      8'h38:   return mRaw & mEna;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string readTag(input logic [7:0] a);
    case (a)
      8'h20:   return "R3";
      8'h2C:   return "R4";
      8'h38:   return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [31:0] wd,
                      input logic [4:0] tx, input logic [3:0] rx, input logic [8:0] co,
                      input string tag, input string irqTag);
    logic [31:0] hw, setV, clrV, eSetV, eClrV;
    logic pend, eoi, nIrq, nArm;
    @(negedge clk);
    busWe = we; busAddr = a; busWdata = wd;
    txEvt = tx; rxEvt = rx; coreEvt = co;
    #1;
    check(busRdata, expRead(a), (tag == "") ? readTag(a) : tag);
    check({31'b0, irqOut}, {31'b0, mIrq}, irqTag);
    @(posedge clk);
    hw    = place(tx, rx, co);
    setV  = (we && a == 8'h24) ? wd : 32'h0;
    clrV  = (we && a == 8'h28) ? wd : 32'h0;
    eSetV = (we && a == 8'h30) ? wd : 32'h0;
    eClrV = (we && a == 8'h34) ? wd : 32'h0;
    eoi   = we && (a == 8'h3C);
    pend  = |(mRaw & mEna);
    nIrq  = ((mArm | eoi) & pend) | (mIrq & pend);
    nArm  = (mArm | eoi) & ~pend;
    mIrq  = nIrq;
    mArm  = nArm;
    mRaw  = ((mRaw & ~clrV) | setV | hw) & VALID_BITS;
    mEna  = ((mEna & ~eClrV) | eSetV) & VALID_BITS;
  endtask

  task automatic rd(input logic [7:0] a, input string tag, input string irqTag);
    step(1'b0, a, 32'h0, '0, '0, '0, tag, irqTag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string irqTag);
    step(1'b1, a, d, '0, '0, '0, "R10", irqTag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0417));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R9: reset state
    #1;
    check({31'b0, irqOut}, 32'h0, "R9");
    rd(8'h20, "R9", "R9");
    rd(8'h2C, "R9", "R9");

    // R1: event pulses land on their bits
    step(1'b0, 8'h00, 32'h0, 5'b00001, 4'b1000, 9'h100, "R10", "R1");
    #1;
    check(busRdata, 32'h0, "R10");
    rd(8'h20, "R1", "R1");
    busAddr = 8'h20; #1;
    check(busRdata, 32'h0100_1001, "R1");

    // R3: clear all while an event hits bit 1 in the same cycle
    step(1'b1, 8'h28, 32'hFFFF_FFFF, 5'b00010, 4'b0000, 9'h000, "R10", "R3");
    rd(8'h20, "R3", "R3");
    busAddr = 8'h20; #1;
    check(busRdata, 32'h0000_0002, "R3");
    wr(8'h28, 32'h0000_0000, "R3");
    rd(8'h20, "R3", "R3");

    // R2: only the implemented pattern can be forced
    wr(8'h24, 32'hFFFF_FFFF, "R2");
    rd(8'h20, "R2", "R2");
    busAddr = 8'h20; #1;
    check(busRdata, VALID_BITS, "R2");

    // R10: read-only and unmapped offsets ignore writes
    wr(8'h20, 32'h0, "R10");
    wr(8'h2C, 32'hFFFF_FFFF, "R10");
    wr(8'h38, 32'h0, "R10");
    wr(8'h44, 32'hFFFF_FFFF, "R10");
    rd(8'h20, "R10", "R10");
    rd(8'h2C, "R10", "R10");
    rd(8'h24, "R10", "R10");
    rd(8'h3C, "R10", "R10");

    // R4 and R6: enable bits, line fires one edge after enable
    wr(8'h30, 32'h0000_0003, "R6");
    rd(8'h38, "R5", "R6");
    rd(8'h38, "R5", "R6");
    busAddr = 8'h38; #1;
    check({31'b0, irqOut}, 32'h1, "R6");
    wr(8'h30, 32'h0100_0000, "R6");
    wr(8'h34, 32'h0000_0001, "R6");
    rd(8'h2C, "R4", "R6");
    busAddr = 8'h2C; #1;
    check(busRdata, 32'h0100_0002, "R4");

    // R7: drop everything, then new sources must not re-fire
    wr(8'h28, 32'hFFFF_FFFF, "R7");
    rd(8'h38, "R5", "R7");
    step(1'b0, 8'h38, 32'h0, 5'b00010, 4'b0000, 9'h100, "R5", "R7");
    rd(8'h38, "R5", "R7");
    rd(8'h38, "R5", "R7");
    busAddr = 8'h38; #1;
    check({31'b0, irqOut}, 32'h0, "R7");

    // R8: end-of-interrupt with sources pending raises the line next edge
    wr(8'h3C, 32'h0, "R8");
    rd(8'h38, "R5", "R8");
    busAddr = 8'h38; #1;
    check({31'b0, irqOut}, 32'h1, "R8");
    wr(8'h28, 32'hFFFF_FFFF, "R8");
    wr(8'h3C, 32'h1234_5678, "R8");
    rd(8'h38, "R5", "R8");
    step(1'b0, 8'h38, 32'h0, 5'b10000, 4'b0000, 9'h000, "R5", "R8");
    rd(8'h38, "R5", "R8");
    busAddr = 8'h38; #1;
    check({31'b0, irqOut}, 32'h0, "R8");
    wr(8'h30, 32'h0000_0010, "R8");
    rd(8'h38, "R5", "R8");
    busAddr = 8'h38; #1;
    check({31'b0, irqOut}, 32'h1, "R8");

    // Constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      logic        we;
      logic [4:0]  tx;
      logic [3:0]  rx;
      logic [8:0]  co;
      int          sel;
      sel = $urandom % 18;
      a   = (sel < 16) ? 8'(sel * 4) : 8'(8'h40 + ($urandom % 16) * 4);
      we  = ($urandom % 3) != 0;
      d   = $urandom & $urandom;
      if ($urandom % 4 == 0) begin
        tx = 5'($urandom & $urandom);
        rx = 4'($urandom & $urandom);
        co = 9'($urandom & $urandom);
      end else begin
        tx = '0; rx = '0; co = '0;
      end
      step(we, a, d, tx, rx, co, "", "R6");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule